// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Upper-Half Write Lock

This block is a slave on a two-wire serial bus that fronts a byte-wide storage array, held in on-chip registers, and behaves like a small serial EEPROM. The system clock oversamples the clock line (SCL) and data line (SDA). The block finds start and stop conditions, checks the device byte, acknowledges the bytes it accepts, and then either takes a word address followed by data bytes or returns stored bytes. The data line is open-drain: the block only ever pulls it low through an output enable.

The array holds `N_BLOCKS` blocks of 256 bytes. Bits of the device byte choose the block, and any device-byte bits not needed for that are matched against strap pins. Written bytes go into a 16-byte page staging buffer and reach the array only when a stop condition arrives. While the protect input is high, bytes headed for the upper half of the array are acknowledged but discarded. Reads go on byte after byte for as long as the master acknowledges.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset the SDA output enable is low, and every array byte reads back as 8'hFF.
- R2: A start condition is SDA falling while SCL is high, and a stop condition is SDA rising while SCL is high. A start at any point begins reception of a new device byte.
- R3: The device byte is accepted only if bits 7:4 are 4'b1010 and each of bits 3:1 that is not used for block select equals the matching strap_i bit. Bit 0 set to 1 means read. A rejected device byte gets no acknowledge, and the block ignores the bus until the next start.
- R4: The slave pulls SDA low during the ninth clock after each byte it accepts: a matching device byte, the word address, and every write data byte.
- R5: Device-byte bits starting at bit 1, log2(N_BLOCKS) of them, form the block number, which becomes the array address bits above bit 7.
- R6: A single write (device byte, word address, one data byte, stop) stores that byte at the addressed location.
- R7: In a page write the low 4 address bits advance after each byte and wrap within the 16-byte page. A later byte sent to the same location replaces an earlier one.
- R8: Written bytes reach the array only at a stop. A start that arrives before the stop discards every pending byte.
- R9: When wp_i is high at the stop, pending bytes whose array address has its top bit set are dropped, while lower-half bytes are still written. The data bytes are acknowledged either way.
- R10: A read returns the byte at the address pointer, which is the word address just set or one past the last byte accessed. The device byte's block bits replace the upper pointer bits.
- R11: Sequential read advances the address across block boundaries and wraps from the last byte to address 0, for as long as the master acknowledges. A not-acknowledge releases SDA and returns the slave to idle.
- R12: The slave starts pulling SDA low only while SCL is low, and it sends bytes most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| wp_i | input | 1 | Write-protect control for the upper half of the array |
| strap_i | input | 3 | Strap values matched against device-byte bits 3:1 that are not used for block select |

## Verification
The bench builds the block with two blocks (512 bytes) and straps of 3'b100. With this setup, device-byte bit 1 selects the block, bit 2 is matched against a strap, and the top array address bit is the block bit. That makes a bad strap, a block-to-block sequential read, and a wrap from the end of the array back to zero all reachable. The bench also drives protected and unprotected writes into the same addresses, page writes that wrap and overwrite within a page, and transactions cut short by a repeated start.

// File: rtl/twi_eeprom_pkg.sv
// Shared constants and state encodings for the two-wire EEPROM slave.
// Assumes nothing beyond IEEE 1800-2017 packages.
package twi_eeprom_pkg;

    // Fixed device-type code expected in device-byte bits 7:4
    localparam logic [3:0] DEV_CODE = 4'b1010;

    // Bus-level protocol state of the slave
    typedef enum logic [2:0] {
        ST_IDLE,     // ignoring the bus until a start
        ST_RX,       // shifting in a byte from the master
        ST_ACKWAIT,  // byte accepted, waiting for SCL low to drive ACK
        ST_ACK,      // ACK clock in progress (or pre-load for transmit)
        ST_TX,       // shifting out a byte to the master
        ST_MACK      // waiting for the master's ACK/NACK
    } twi_state_e;

    // Meaning of the next byte received
    typedef enum logic [1:0] {
        BY_DEV,
        BY_WORD,
        BY_DATA
    } byte_kind_e;

endpackage

// File: rtl/twi_line_sync.sv
// Synchronises SCL and SDA into the system clock domain and derives
// SCL edges plus start/stop events. Assumes the system clock runs several
// times faster than SCL so that every bus level lasts more than a few cycles.
module twi_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [SYNC_STAGES-1:0] scl_ff;
    logic [SYNC_STAGES-1:0] sda_ff;
    logic                   scl_prev;
    logic                   sda_prev;

    // Synchroniser chains plus one history stage; idle bus level is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff   <= '1;
            sda_ff   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_ff   <= {scl_ff[SYNC_STAGES-2:0], scl_i};
            sda_ff   <= {sda_ff[SYNC_STAGES-2:0], sda_i};
            scl_prev <= scl_ff[SYNC_STAGES-1];
            sda_prev <= sda_ff[SYNC_STAGES-1];
        end
    end

    // Edge and condition decode on the synchronised levels
    always_comb begin
        scl_o      = scl_ff[SYNC_STAGES-1];
        sda_o      = sda_ff[SYNC_STAGES-1];
        scl_rise_o = scl_o & ~scl_prev;
        scl_fall_o = ~scl_o & scl_prev;
        start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
        stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;
    end

endmodule

// File: rtl/twi_eeprom_store.sv
// Byte array plus a one-page staging buffer. Bytes are staged during a
// write transaction and copied into the array at commit (stop condition),
// unless write protect is set and the page lies in the upper half.
// Assumes the page base does not change between staging and commit.
module twi_eeprom_store #(
    parameter int N_BLOCKS = 2,
    parameter int PAGE_W   = 4
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       clear_i,
    input  logic                                       commit_i,
    input  logic                                       stage_we_i,
    input  logic [PAGE_W-1:0]                          stage_idx_i,
    input  logic [7:0]                                 stage_data_i,
    input  logic [$clog2(N_BLOCKS*256)-PAGE_W-1:0]     base_i,
    input  logic                                       wp_i,
    input  logic [$clog2(N_BLOCKS*256)-1:0]            rd_addr_i,
    output logic [7:0]                                 rd_data_o
);

    localparam int DEPTH  = N_BLOCKS * 256;
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int BASE_W = ADDR_W - PAGE_W;
    localparam int PAGE_N = 1 << PAGE_W;

    logic [7:0]        mem_q   [DEPTH];
    logic [7:0]        stage_q [PAGE_N];
    logic [PAGE_N-1:0] valid_q;
    logic              blocked;

    // Upper-half pages are locked while protect is high
    always_comb blocked = wp_i & base_i[BASE_W-1];

    // Staging buffer: capture bytes, forget them at commit or abort
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (commit_i || clear_i) begin
            valid_q <= '0;
        end else if (stage_we_i) begin
            valid_q[stage_idx_i] <= 1'b1;
            stage_q[stage_idx_i] <= stage_data_i;
        end
    end

    // Array: erased on reset, written with valid staged bytes at commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (commit_i && !blocked) begin
            for (int i = 0; i < PAGE_N; i++) begin
                if (valid_q[i]) mem_q[{base_i, PAGE_W'(i)}] <= stage_q[i];
            end
        end
    end

    // Asynchronous read port
    always_comb rd_data_o = mem_q[rd_addr_i];

    // R8: array contents change only in the cycle after a commit
    a_r8_hold_between_stops: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> (mem_q[$past(rd_addr_i)] == $past(rd_data_o)));

    // R9: with protect high, an upper-half location survives a commit
    a_r9_upper_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && wp_i && rd_addr_i[ADDR_W-1]) |=>
            (mem_q[$past(rd_addr_i)] == $past(rd_data_o)));

endmodule

// File: rtl/twi_eeprom_ctrl.sv
// Protocol engine: receives device, word and data bytes, drives ACKs and
// read data, keeps the address pointer, and hands bytes to the store.
// Assumes synchronised inputs and edge strobes from twi_line_sync.
module twi_eeprom_ctrl
    import twi_eeprom_pkg::*;
#(
    parameter int N_BLOCKS = 2,
    parameter int PAGE_W   = 4
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       scl_s,
    input  logic                                       sda_s,
    input  logic                                       scl_rise,
    input  logic                                       scl_fall,
    input  logic                                       start_det,
    input  logic                                       stop_det,
    input  logic [2:0]                                 strap_i,
    input  logic [7:0]                                 rd_data_i,
    output logic [$clog2(N_BLOCKS*256)-1:0]            rd_addr_o,
    output logic                                       stage_we_o,
    output logic [PAGE_W-1:0]                          stage_idx_o,
    output logic [7:0]                                 stage_data_o,
    output logic [$clog2(N_BLOCKS*256)-PAGE_W-1:0]     base_o,
    output logic                                       commit_o,
    output logic                                       clear_o,
    output logic                                       sda_oe_o
);

    localparam int         ADDR_W   = $clog2(N_BLOCKS * 256);
    localparam logic [2:0] BLK_MASK = 3'(N_BLOCKS - 1);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(8'hFF);

    twi_state_e        state_q;
    byte_kind_e        kind_q;
    logic [2:0]        cnt_q;
    logic [7:0]        sh_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              go_tx_q;
    logic              ack_oe_q;

    logic [7:0]        byte_in;
    logic              dev_hit;
    logic [2:0]        blk_sel;
    logic [ADDR_W-1:0] ptr_blk;
    logic [ADDR_W-1:0] ptr_word;
    logic [ADDR_W-1:0] ptr_page;
    logic              byte_end;

    // Byte assembly, device-byte decode and pointer candidates
    always_comb begin
        byte_in  = {sh_q[6:0], sda_s};
        dev_hit  = (byte_in[7:4] == DEV_CODE) &&
                   (((byte_in[3:1] ^ strap_i) & ~BLK_MASK) == 3'b000);
        blk_sel  = byte_in[3:1] & BLK_MASK;
        ptr_blk  = (ptr_q & LOW_MASK) | (ADDR_W'(blk_sel) << 8);
        ptr_word = (ptr_q & ~LOW_MASK) | ADDR_W'(byte_in);
        ptr_page = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + 1'b1};
        byte_end = (state_q == ST_RX) && scl_rise && (cnt_q == 3'd7);
    end

    // Interface to the store and the pad
    always_comb begin
        rd_addr_o    = ptr_q;
        stage_we_o   = byte_end && (kind_q == BY_DATA);
        stage_idx_o  = ptr_q[PAGE_W-1:0];
        stage_data_o = byte_in;
        base_o       = ptr_q[ADDR_W-1:PAGE_W];
        commit_o     = stop_det;
        clear_o      = start_det;
        sda_oe_o     = ack_oe_q | ((state_q == ST_TX) & ~sh_q[7]);
    end

    // Protocol state machine, one bus event per cycle at most
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            kind_q   <= BY_DEV;
            cnt_q    <= '0;
            sh_q     <= '0;
            ptr_q    <= '0;
            go_tx_q  <= 1'b0;
            ack_oe_q <= 1'b0;
        end else if (start_det) begin
            state_q  <= ST_RX;
            kind_q   <= BY_DEV;
            cnt_q    <= '0;
            go_tx_q  <= 1'b0;
            ack_oe_q <= 1'b0;
        end else if (stop_det) begin
            state_q  <= ST_IDLE;
            ack_oe_q <= 1'b0;
        end else begin
            case (state_q)
                ST_RX: begin
                    if (scl_rise) begin
                        sh_q  <= byte_in;
                        cnt_q <= cnt_q + 3'd1;
                        if (cnt_q == 3'd7) begin
                            state_q <= ST_ACKWAIT;
                            case (kind_q)
                                BY_DEV: begin
                                    if (dev_hit) begin
                                        ptr_q   <= ptr_blk;
                                        go_tx_q <= byte_in[0];
                                        kind_q  <= BY_WORD;
                                    end else begin
                                        state_q <= ST_IDLE;
                                    end
                                end
                                BY_WORD: begin
                                    ptr_q  <= ptr_word;
                                    kind_q <= BY_DATA;
                                end
                                default: ptr_q <= ptr_page;
                            endcase
                        end
                    end
                end
                ST_ACKWAIT: begin
                    if (scl_fall) begin
                        ack_oe_q <= 1'b1;
                        state_q  <= ST_ACK;
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        ack_oe_q <= 1'b0;
                        cnt_q    <= '0;
                        if (go_tx_q) begin
                            sh_q    <= rd_data_i;
                            ptr_q   <= ptr_q + 1'b1;
                            state_q <= ST_TX;
                        end else begin
                            state_q <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (cnt_q == 3'd7) begin
                            cnt_q   <= '0;
                            state_q <= ST_MACK;
                        end else begin
                            sh_q  <= {sh_q[6:0], 1'b0};
                            cnt_q <= cnt_q + 3'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) state_q <= sda_s ? ST_IDLE : ST_ACK;
                end
                default: ;
            endcase
        end
    end

    // R12: pulling SDA low only ever begins while SCL is low
    a_r12_drive_begins_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_s);

    // R11: an idle slave never holds the data line
    a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_oe_o);

    // R4: entering the ACK clock after an accepted byte drives SDA low
    a_r4_ack_driven: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_ACKWAIT && state_q == ST_ACK) |-> sda_oe_o);

    // R7: a data byte never moves the pointer out of its page
    a_r7_page_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q == ST_RX && kind_q == BY_DATA) && state_q == ST_ACKWAIT)
            |-> $stable(ptr_q[ADDR_W-1:PAGE_W]));

endmodule

// File: rtl/twi_eeprom_slave.sv
// Top level of the two-wire EEPROM slave: line synchroniser, protocol
// engine and storage. N_BLOCKS must be 1, 2, 4 or 8; SDA is open drain and
// sda_oe_o high means the pad pulls the line low.
module twi_eeprom_slave #(
    parameter int N_BLOCKS    = 2,
    parameter int PAGE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic       wp_i,
    input  logic [2:0] strap_i
);

    localparam int ADDR_W = $clog2(N_BLOCKS * 256);
    localparam int BASE_W = ADDR_W - PAGE_W;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data;
    logic              stage_we, commit, clear;
    logic [PAGE_W-1:0] stage_idx;
    logic [7:0]        stage_data;
    logic [BASE_W-1:0] base;

    twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    twi_eeprom_ctrl #(.N_BLOCKS(N_BLOCKS), .PAGE_W(PAGE_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_s        (scl_s),
        .sda_s        (sda_s),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .strap_i      (strap_i),
        .rd_data_i    (rd_data),
        .rd_addr_o    (rd_addr),
        .stage_we_o   (stage_we),
        .stage_idx_o  (stage_idx),
        .stage_data_o (stage_data),
        .base_o       (base),
        .commit_o     (commit),
        .clear_o      (clear),
        .sda_oe_o     (sda_oe_o)
    );

    twi_eeprom_store #(.N_BLOCKS(N_BLOCKS), .PAGE_W(PAGE_W)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (clear),
        .commit_i     (commit),
        .stage_we_i   (stage_we),
        .stage_idx_i  (stage_idx),
        .stage_data_i (stage_data),
        .base_i       (base),
        .wp_i         (wp_i),
        .rd_addr_i    (rd_addr),
        .rd_data_o    (rd_data)
    );

endmodule

// File: tb/twi_eeprom_slave_bench.sv
// Directed bench: a bit-banged bus master, one task per scenario.
`timescale 1ns/1ps
module twi_eeprom_slave_bench;

    localparam logic [2:0] STRAP = 3'b100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic wp = 1'b0;
    logic sda_oe;
    logic line;
    logic oe_d = 1'b0;
    logic done = 1'b0;
    int   n_chk = 0;
    int   n_bad = 0;
    int   mon_bad = 0;
    logic [7:0] wbuf [0:31];
    logic [7:0] rbuf [0:31];

    always #2.5 clk = ~clk;

    assign line = ~(sda_oe | m_low);

    twi_eeprom_slave u_twi_eeprom_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (line),
        .sda_oe_o (sda_oe),
        .wp_i     (wp),
        .strap_i  (STRAP)
    );

    // R12 monitor: the slave must not begin pulling SDA while SCL is high
    always @(posedge clk) begin
        if (rst_n && sda_oe && !oe_d && m_scl) mon_bad++;
        oe_d <= sda_oe;
    end

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] dev(input logic blk, input logic rd);
        return {4'b1010, STRAP[2:1], blk, rd};
    endfunction

    task automatic bus_start();
        m_low = 1'b0; tick(5);
        m_scl = 1'b1; tick(10);
        m_low = 1'b1; tick(10);
        m_scl = 1'b0; tick(3);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(7);
        m_scl = 1'b1; tick(10);
        m_low = 1'b0; tick(10);
    endtask

    task automatic bit_cycle(input logic drive_low, output logic seen);
        m_low = drive_low; tick(7);
        m_scl = 1'b1; tick(5);
        seen = line; tick(5);
        m_scl = 1'b0; tick(3);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(~b[i], s);
        bit_cycle(1'b0, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b0, s);
            b[i] = s;
        end
        bit_cycle(give_ack, s);
    endtask

    task automatic write_page(input logic blk, input logic [7:0] addr, input int n, input string req);
        logic ack;
        bus_start();
        send_byte(dev(blk, 1'b0), ack); check1({req, " R4 device ack"}, ack, 1'b1);
        send_byte(addr, ack);           check1({req, " R4 word ack"}, ack, 1'b1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack);    check1({req, " R4 data ack"}, ack, 1'b1);
        end
        bus_stop();
    endtask

    task automatic read_rand(input logic blk, input logic [7:0] addr, input int n);
        logic ack;
        bus_start();
        send_byte(dev(blk, 1'b0), ack); check1("R4 read setup ack", ack, 1'b1);
        send_byte(addr, ack);           check1("R4 read word ack", ack, 1'b1);
        bus_start();
        send_byte(dev(blk, 1'b1), ack); check1("R4 read device ack", ack, 1'b1);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        check1("R11 SDA released after NACK", sda_oe, 1'b0);
        bus_stop();
    endtask

    task automatic t_reset();
        check1("R1 oe low after reset", sda_oe, 1'b0);
        read_rand(1'b0, 8'h10, 1); check8("R1 erased block0", rbuf[0], 8'hFF);
        read_rand(1'b1, 8'hAB, 1); check8("R1 erased block1", rbuf[0], 8'hFF);
    endtask

    task automatic t_single();
        wbuf[0] = 8'h5A;
        write_page(1'b0, 8'h23, 1, "R6");
        read_rand(1'b0, 8'h23, 1); check8("R6 single write", rbuf[0], 8'h5A);
    endtask

    task automatic t_mismatch();
        logic ack;
        bus_start();
        send_byte(8'hA0, ack); check1("R3 wrong strap no ack", ack, 1'b0);
        send_byte(8'h23, ack); check1("R3 ignored after reject", ack, 1'b0);
        send_byte(8'h99, ack); check1("R3 ignored data", ack, 1'b0);
        bus_stop();
        bus_start();
        send_byte(8'hB8, ack); check1("R3 wrong type code no ack", ack, 1'b0);
        bus_stop();
        read_rand(1'b0, 8'h23, 1); check8("R3 rejected write left array", rbuf[0], 8'h5A);
    endtask

    task automatic t_blocks();
        wbuf[0] = 8'hC3;
        write_page(1'b1, 8'h23, 1, "R5");
        read_rand(1'b0, 8'h23, 1); check8("R5 block0 untouched", rbuf[0], 8'h5A);
        read_rand(1'b1, 8'h23, 1); check8("R5 block1 written", rbuf[0], 8'hC3);
    endtask

    task automatic t_page();
        for (int i = 0; i < 6; i++) wbuf[i] = 8'h10 + 8'(i);
        write_page(1'b0, 8'h4E, 6, "R7");
        read_rand(1'b0, 8'h40, 16);
        for (int i = 0; i < 16; i++) begin
            logic [7:0] e;
            if (i < 4)       e = 8'h12 + 8'(i);
            else if (i < 14) e = 8'hFF;
            else             e = 8'h10 + 8'(i - 14);
            check8("R7 page wrap", rbuf[i], e);
        end
        for (int i = 0; i < 17; i++) wbuf[i] = 8'h80 + 8'(i);
        write_page(1'b0, 8'h50, 17, "R7");
        read_rand(1'b0, 8'h50, 2);
        check8("R7 overwrite by wrap", rbuf[0], 8'h90);
        check8("R7 next in page", rbuf[1], 8'h81);
    endtask

    task automatic t_abort();
        logic ack;
        bus_start();
        send_byte(dev(1'b0, 1'b0), ack); check1("R2 device ack", ack, 1'b1);
        send_byte(8'h60, ack);           check1("R2 word ack", ack, 1'b1);
        send_byte(8'h11, ack);           check1("R8 data ack", ack, 1'b1);
        bus_start();
        bus_stop();
        check1("R2 released after stop", sda_oe, 1'b0);
        read_rand(1'b0, 8'h60, 1); check8("R8 aborted write discarded", rbuf[0], 8'hFF);
    endtask

    task automatic t_protect();
        wp = 1'b1;
        wbuf[0] = 8'h77; write_page(1'b1, 8'h10, 1, "R9");
        wbuf[0] = 8'h66; write_page(1'b0, 8'h10, 1, "R9");
        read_rand(1'b1, 8'h10, 1); check8("R9 upper half dropped", rbuf[0], 8'hFF);
        read_rand(1'b0, 8'h10, 1); check8("R9 lower half written", rbuf[0], 8'h66);
        wp = 1'b0;
        wbuf[0] = 8'h78; write_page(1'b1, 8'h10, 1, "R9");
        read_rand(1'b1, 8'h10, 1); check8("R9 upper writable when off", rbuf[0], 8'h78);
    endtask

    task automatic t_seq();
        logic ack;
        wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; write_page(1'b0, 8'hFE, 2, "R11");
        wbuf[0] = 8'hB1; wbuf[1] = 8'hB2; write_page(1'b1, 8'h00, 2, "R11");
        read_rand(1'b0, 8'hFE, 3);
        check8("R11 seq byte0", rbuf[0], 8'hA1);
        check8("R11 seq byte1", rbuf[1], 8'hA2);
        check8("R11 seq crosses block", rbuf[2], 8'hB1);
        bus_start();
        send_byte(dev(1'b1, 1'b1), ack); check1("R10 current read ack", ack, 1'b1);
        recv_byte(1'b0, rbuf[0]);
        bus_stop();
        check8("R10 current address read", rbuf[0], 8'hB2);
        wbuf[0] = 8'hE7; write_page(1'b1, 8'hFF, 1, "R11");
        wbuf[0] = 8'hE8; write_page(1'b0, 8'h00, 1, "R11");
        read_rand(1'b1, 8'hFF, 2);
        check8("R11 last byte", rbuf[0], 8'hE7);
        check8("R11 wrap to zero", rbuf[1], 8'hE8);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        tick(10);
        t_reset();
        t_single();
        t_mismatch();
        t_blocks();
        t_page();
        t_abort();
        t_protect();
        t_seq();
        check1("R12 no drive start with SCL high", mon_bad == 0, 1'b1);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule